// File: doc/BRIEF.md
# Serial Video Lane Word Error Monitor

This block watches the aligned 10-bit words arriving on several colour lanes of a transition-minimised serial video link and estimates how healthy each lane is. Every valid word is sorted into one of two classes: one of the four reserved control codes, or a data word. A data word is counted as corrupted when the adjacent-bit changes in its low eight bits exceed what the encoder can produce.

Counting runs over a fixed window of valid words that all lanes share. When a window closes, the per-lane counts are captured into held rate outputs and a single-cycle report pulse tells software to read them. A rate of zero means a clean lane. A handful of errors per window is still usable for display. Deserialisation, alignment, decoding and register access are handled elsewhere.

Top module: `lane_err_monitor`

## Requirements
- R1: The words 10'b1101010100, 10'b0010101011, 10'b0101010100 and 10'b1010101011 (bit 9 written first) are control codes and never add to any count, whatever their bit pattern.
- R2: Any other valid word adds one to its lane's count exactly when the number of positions i in 0..6 with word[i] != word[i+1] is greater than 4.
- R3: A window is 2**WIN_LOG2 cycles with wordValid high. Cycles with wordValid low neither count errors nor advance the window.
- R4: In the cycle after the last valid word of a window, reportStb is high for exactly one cycle. Each lane's errRate then shows the count for the whole window, including that last word.
- R5: errRate keeps its value until the next window closes.
- R6: A lane's count saturates at 2**CNT_W-1 instead of wrapping.
- R7: Each lane is counted independently from the word on its own slice words[ch*10 +: 10] and reported on errRate[ch*CNT_W +: CNT_W].
- R8: A synchronous, active-high rst clears the window position, the running counts and errRate, and holds reportStb low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| wordValid | input | 1 | Qualifies the words of all lanes in this cycle |
| words | input | NUM_CH*10 | Aligned received words, lane 0 in the low bits |
| errRate | output | NUM_CH*CNT_W | Held error count of the last finished window, per lane |
| reportStb | output | 1 | One-cycle pulse when errRate has been refreshed |

## Verification
The hardest condition to reach from the ports is the saturation ceiling. A count has to pass its maximum inside one window while the neighbouring lanes carry other values, and the ceiling must hold exactly at the window boundary. The bench uses a small configuration of an 8-word window and a 3-bit count. In that configuration, a window made entirely of maximal-toggle data words on one lane passes the ceiling. The bench places it next to a window of exactly seven errors, which lands on the ceiling without saturating. Before that, a sweep of all 1024 word values across the three lanes, with idle cycles carrying error patterns, exercises the classification and the window bookkeeping.

// File: rtl/lane_err_pkg.sv
package lane_err_pkg;
  localparam int WORD_W      = 10;
  localparam int SCAN_BITS   = 8;
  localparam int MAX_TOGGLES = 4;

  typedef struct packed {
    logic take;   // a valid word is present this cycle
    logic close;  // this valid word is the last of the window
  } winCmd_t;

  function automatic logic isCtrlCode(input logic [WORD_W-1:0] w);
    return (w == 10'b1101010100) || (w == 10'b0010101011) ||
           (w == 10'b0101010100) || (w == 10'b1010101011);
  endfunction

  function automatic logic [3:0] toggleCount(input logic [WORD_W-1:0] w);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < SCAN_BITS - 1; i++) begin
      n = n + {3'b000, (w[i] ^ w[i+1])};
    end
    return n;
  endfunction
endpackage

// File: rtl/lane_err_window_ctrl.sv
module lane_err_window_ctrl
  import lane_err_pkg::*;
#(
  parameter int WIN_LOG2 = 24
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    wordValid,
  output winCmd_t cmd,
  output logic    reportStb
);
  logic [WIN_LOG2-1:0] wordIdx;
  logic                lastWord;

  assign lastWord = &wordIdx;

  always_comb begin
    cmd.take  = wordValid;
    cmd.close = wordValid && lastWord;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wordIdx   <= '0;
      reportStb <= 1'b0;
    end else begin
      reportStb <= wordValid && lastWord;
      if (wordValid) wordIdx <= wordIdx + 1'b1;
    end
  end
endmodule

// File: rtl/lane_err_datapath.sv
module lane_err_datapath
  import lane_err_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  winCmd_t                  cmd,
  input  logic [NUM_CH*WORD_W-1:0] words,
  output logic [NUM_CH*CNT_W-1:0]  errRate
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    logic [WORD_W-1:0] laneWord;
    logic              hit;
    logic [CNT_W-1:0]  acc;
    logic [CNT_W-1:0]  nextAcc;
    logic [CNT_W-1:0]  rate;

    assign laneWord = words[ch*WORD_W +: WORD_W];
    assign hit      = cmd.take && !isCtrlCode(laneWord) &&
                      (toggleCount(laneWord) > 4'(MAX_TOGGLES));
    assign nextAcc  = (hit && (acc != CNT_MAX)) ? acc + 1'b1 : acc;

    always_ff @(posedge clk) begin
      if (rst) begin
        acc  <= '0;
        rate <= '0;
      end else if (cmd.close) begin
        rate <= nextAcc;
        acc  <= '0;
      end else if (cmd.take) begin
        acc  <= nextAcc;
      end
    end

    assign errRate[ch*CNT_W +: CNT_W] = rate;
  end
endmodule

// File: rtl/lane_err_monitor.sv
module lane_err_monitor
  import lane_err_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int WIN_LOG2 = 24,
  parameter int CNT_W    = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wordValid,
  input  logic [NUM_CH*WORD_W-1:0] words,
  output logic [NUM_CH*CNT_W-1:0]  errRate,
  output logic                     reportStb
);
  winCmd_t cmd;

  lane_err_window_ctrl #(.WIN_LOG2(WIN_LOG2)) ctrl_i (
    .clk(clk), .rst(rst), .wordValid(wordValid),
    .cmd(cmd), .reportStb(reportStb)
  );

  lane_err_datapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst(rst), .cmd(cmd), .words(words), .errRate(errRate)
  );
endmodule

// File: rtl/lane_err_monitor_chk.sv
module lane_err_monitor_chk #(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 24
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wordValid,
  input logic [NUM_CH*CNT_W-1:0] errRate,
  input logic                    reportStb
);
  logic rstSeen;
  always_ff @(posedge clk) rstSeen <= rst;

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    reportStb |=> !reportStb); // R4

  AST_STB_NEEDS_WORD: assert property (@(posedge clk) disable iff (rst)
    reportStb |-> $past(wordValid)); // R3

  AST_RATE_HELD: assert property (@(posedge clk) disable iff (rst)
    !reportStb |-> $stable(errRate)); // R5

  always_ff @(posedge clk) begin
    if (rstSeen && !rst) begin
      AST_RESET_CLEARS: assert (errRate == '0 && !reportStb); // R8
    end
  end
endmodule

bind lane_err_monitor lane_err_monitor_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .wordValid(wordValid),
  .errRate(errRate), .reportStb(reportStb)
);

// File: tb/lane_err_monitor_tb.sv
module lane_err_monitor_tb_top;
  localparam int PERIOD   = 10;
  localparam int NUM_CH   = 3;
  localparam int WIN_LOG2 = 3;
  localparam int CNT_W    = 3;
  localparam int WIN      = 1 << WIN_LOG2;
  localparam int CMAX     = (1 << CNT_W) - 1;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    wordValid = 1'b0;
  logic [NUM_CH*10-1:0]    words = '0;
  logic [NUM_CH*CNT_W-1:0] errRate;
  logic                    reportStb;

  int vectors = 0;
  int fails   = 0;
  int mAcc [NUM_CH];
  int expRate [NUM_CH];
  int mIdx = 0;
  bit expStb = 1'b0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  lane_err_monitor #(.NUM_CH(NUM_CH), .WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .wordValid(wordValid), .words(words),
    .errRate(errRate), .reportStb(reportStb)
  );

  // Reference: reserved codes never count (R1), otherwise more than 4 changes in bits 7..0 (R2)
  function automatic bit refErr(input int w);
    int t;
    if (w == 'b1101010100 || w == 'b0010101011 || w == 'b0101010100 || w == 'b1010101011)
      return 1'b0;
    t = 0;
    for (int i = 0; i < 7; i++) t += ((w >> i) & 1) ^ ((w >> (i + 1)) & 1);
    return t > 4;
  endfunction

  task automatic checkOutputs(input string tag);
    vectors++;
    if (reportStb !== expStb) begin
      fails++;
      $display("FAIL R4 reportStb actual=%0b expected=%0b", reportStb, expStb);
    end
    for (int ch = 0; ch < NUM_CH; ch++) begin
      vectors++;
      if (errRate[ch*CNT_W +: CNT_W] !== CNT_W'(expRate[ch])) begin
        fails++;
        $display("FAIL %s lane %0d errRate actual=%0d expected=%0d",
                 tag, ch, errRate[ch*CNT_W +: CNT_W], expRate[ch]);
      end
    end
  endtask

  // One cycle: check what the last edge produced, drive, advance the model (R3 R4 R6 R7)
  task automatic step(input string tag, input bit v, input int w0, input int w1, input int w2);
    int w [NUM_CH];
    int s;
    w[0] = w0; w[1] = w1; w[2] = w2;
    @(negedge clk);
    checkOutputs(tag);
    wordValid = v;
    for (int ch = 0; ch < NUM_CH; ch++) words[ch*10 +: 10] = 10'(w[ch]);
    expStb = v && (mIdx == WIN - 1);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      s = mAcc[ch] + ((v && refErr(w[ch])) ? 1 : 0);
      if (s > CMAX) s = CMAX;
      if (expStb) begin
        expRate[ch] = s;
        mAcc[ch] = 0;
      end else if (v) begin
        mAcc[ch] = s;
      end
    end
    if (v) mIdx = (mIdx + 1) % WIN;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    wordValid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mIdx = 0;
    expStb = 1'b0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      mAcc[ch] = 0;
      expRate[ch] = 0;
    end
    checkOutputs("R8");
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    doReset(); // R8 reset state

    // Sweep all word values; idle cycles carry error patterns that must be ignored (R3)
    for (int n = 0; n < 1024; n++) begin
      if (n % 5 == 4) step("R3", 1'b0, 'h155, 'h2AA, 'h155);
      step("R1/R2/R7", 1'b1, n, (n * 37 + 5) % 1024, (~n) & 'h3FF);
    end

    // One lane overflows while the others stay clean or carry control codes (R6, R1)
    for (int i = 0; i < WIN; i++) step("R6", 1'b1, 'h155, 0, 'b0101010100);
    // Exactly seven errors lands on the ceiling; the last word is clean (R4)
    for (int i = 0; i < WIN; i++) step("R6", 1'b1, (i < 7) ? 'h2AA : 0, 'b1101010100, 'h155);
    // Held value across a long idle gap (R5)
    for (int i = 0; i < 12; i++) step("R5", 1'b0, 'h155, 'h155, 'h155);

    // Reset in mid-window, then a clean window must report zero after a full window (R8)
    for (int i = 0; i < 3; i++) step("R8", 1'b1, 'h155, 'h155, 'h155);
    doReset();
    for (int i = 0; i < WIN + 2; i++) step("R8", 1'b1, 0, 'b0010101011, 'b1010101011);

    @(negedge clk);
    checkOutputs("R4");
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule